// File: doc/BRIEF.md
# Bus Error State Monitor

This block sits beside a controller-area-network protocol engine and turns that engine's raw error counters into a small set of fault-confinement status bits. The engine supplies an 8-bit receive error count and a 9-bit transmit error count. From these the block derives, on every clock, a warning level, an error-passive level and a bus-off state. It also keeps one sticky overflow bit for each receive buffer. The engine reports an overflow when it has a complete, accepted message and the target buffer is still occupied.

Any change of the derived state, in either direction, produces a single one-cycle error interrupt pulse. Every overflow event produces the same pulse. The host reads the status bits and acknowledges an overflow with a per-buffer clear strobe. The counter-derived bits cannot be written by the host. The overflow bits can be cleared by the host but never set by it.

Top module: `bus_err_mon`

## Requirements
- R1: A synchronous active-high reset clears every status bit, every overflow bit and the interrupt output. All of them read 0 in the cycle after a reset edge.
- R2: `rx_warn` is 1 exactly when the receive count sampled at the previous clock edge was 96 or more.
- R3: `tx_warn` is 1 exactly when the transmit count sampled at the previous clock edge was 96 or more.
- R4: `rx_passive` is 1 exactly when the receive count sampled at the previous clock edge was above 127.
- R5: `tx_passive` is 1 exactly when the transmit count sampled at the previous clock edge was above 127. This includes counts that also mean bus-off.
- R6: `bus_off` is 1 exactly when the transmit count sampled at the previous clock edge was above 255.
- R7: `any_warn` always equals `rx_warn` OR `tx_warn`.
- R8: Bit i of `rx_ovf` (bit 0 is buffer 0, bit 1 is buffer 1) is set one cycle after `rx_ovf_evt[i]` is high. It then stays set until a cycle where `ovf_clr[i]` is high and `rx_ovf_evt[i]` is low; in that case it reads 0 one cycle later. When the event and the clear arrive in the same cycle, the event wins. A clear strobe on an already clear bit has no effect.
- R9: `err_irq` is high for exactly the one cycle in which the five counter-derived bits take a value different from the cycle before. This applies to both rising and falling changes.
- R10: `err_irq` is high in the cycle after any `rx_ovf_evt` bit is high. This holds even when the matching overflow bit is already set.
- R11: `err_irq` is low when the derived bits are unchanged and no overflow event arrived in the previous cycle. Clearing an overflow bit does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_err_cnt | input | 8 | Receive error count from the protocol engine |
| tx_err_cnt | input | 9 | Transmit error count from the protocol engine |
| rx_ovf_evt | input | 2 | Per-buffer receive overflow event, one cycle each |
| ovf_clr | input | 2 | Host clear strobe, one per overflow bit |
| rx_warn | output | 1 | Receive count at warning level |
| tx_warn | output | 1 | Transmit count at warning level |
| any_warn | output | 1 | Either warning bit set |
| rx_passive | output | 1 | Receiver error-passive |
| tx_passive | output | 1 | Transmitter error-passive |
| bus_off | output | 1 | Transmitter bus-off |
| rx_ovf | output | 2 | Sticky overflow bits, bit i for buffer i |
| err_irq | output | 1 | One-cycle error interrupt pulse |

## Verification
The bound checker tests, on every cycle, that each threshold bit matches the counts of the previous edge and that the summary warning bit matches the two warning bits. It also tests that an overflow event sets its bit and that a set bit holds without a clear. For the interrupt pulse, it tests that a state change or an overflow event raises it and that a quiet cycle keeps it low. The bench walks the counters across each boundary (95/96, 127/128, 255/256) and checks that repeating a state gives no pulse. Its directed scenarios cover cases the properties do not tie to a stimulus sequence: a clear on an empty bit, a set that collides with a clear, a repeated event on a set bit, and a reset with the counters held high.

// File: rtl/bem_pkg.sv
package bem_pkg;
  // counter-derived fault confinement state
  typedef struct packed {
    logic bus_off;
    logic tx_pas;
    logic rx_pas;
    logic tx_warn;
    logic rx_warn;
  } fault_st_t;

  localparam int FAULT_BITS = $bits(fault_st_t);
endpackage

// File: rtl/bem_thresh.sv
module bem_thresh
  import bem_pkg::*;
#(
  parameter int RX_W      = 8,
  parameter int TX_W      = 9,
  parameter int WARN_LIM  = 96,
  parameter int PAS_LIM   = 127,
  parameter int BOFF_LIM  = 255
) (
  input  logic [RX_W-1:0] rx_cnt,
  input  logic [TX_W-1:0] tx_cnt,
  output fault_st_t       st
);
  localparam logic [RX_W-1:0] RX_WARN = RX_W'(WARN_LIM);
  localparam logic [RX_W-1:0] RX_PAS  = RX_W'(PAS_LIM);
  localparam logic [TX_W-1:0] TX_WARN = TX_W'(WARN_LIM);
  localparam logic [TX_W-1:0] TX_PAS  = TX_W'(PAS_LIM);
  localparam logic [TX_W-1:0] TX_BOFF = TX_W'(BOFF_LIM);

  always_comb begin
    st.rx_warn = (rx_cnt >= RX_WARN);
    st.tx_warn = (tx_cnt >= TX_WARN);
    st.rx_pas  = (rx_cnt >  RX_PAS);
    st.tx_pas  = (tx_cnt >  TX_PAS);
    st.bus_off = (tx_cnt >  TX_BOFF);
  end
endmodule

// File: rtl/bem_ovf.sv
module bem_ovf #(
  parameter int NBUF = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NBUF-1:0] evt,
  input  logic [NBUF-1:0] clr,
  output logic [NBUF-1:0] ovf
);
  for (genvar i = 0; i < NBUF; i++) begin : g_buf
    always_ff @(posedge clk) begin
      if (rst)
        ovf[i] <= 1'b0;
      else if (evt[i])
        ovf[i] <= 1'b1;          // a new event beats a clear
      else if (clr[i])
        ovf[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/bem_change.sv
module bem_change
  import bem_pkg::*;
#(
  parameter int NBUF = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  fault_st_t       st_d,
  input  logic [NBUF-1:0] ovf_evt,
  output fault_st_t       st_q,
  output logic            irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
      irq  <= 1'b0;
    end else begin
      st_q <= st_d;
      irq  <= (st_d != st_q) || (|ovf_evt);
    end
  end
endmodule

// File: rtl/bus_err_mon.sv
module bus_err_mon
  import bem_pkg::*;
#(
  parameter int RX_W     = 8,
  parameter int TX_W     = 9,
  parameter int NBUF     = 2,
  parameter int WARN_LIM = 96,
  parameter int PAS_LIM  = 127,
  parameter int BOFF_LIM = 255
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RX_W-1:0] rx_err_cnt,
  input  logic [TX_W-1:0] tx_err_cnt,
  input  logic [NBUF-1:0] rx_ovf_evt,
  input  logic [NBUF-1:0] ovf_clr,
  output logic            rx_warn,
  output logic            tx_warn,
  output logic            any_warn,
  output logic            rx_passive,
  output logic            tx_passive,
  output logic            bus_off,
  output logic [NBUF-1:0] rx_ovf,
  output logic            err_irq
);
  fault_st_t st_d, st_q;

  bem_thresh #(
    .RX_W(RX_W), .TX_W(TX_W),
    .WARN_LIM(WARN_LIM), .PAS_LIM(PAS_LIM), .BOFF_LIM(BOFF_LIM)
  ) u_thresh (
    .rx_cnt(rx_err_cnt),
    .tx_cnt(tx_err_cnt),
    .st    (st_d)
  );

  bem_change #(.NBUF(NBUF)) u_change (
    .clk    (clk),
    .rst    (rst),
    .st_d   (st_d),
    .ovf_evt(rx_ovf_evt),
    .st_q   (st_q),
    .irq    (err_irq)
  );

  bem_ovf #(.NBUF(NBUF)) u_ovf (
    .clk(clk),
    .rst(rst),
    .evt(rx_ovf_evt),
    .clr(ovf_clr),
    .ovf(rx_ovf)
  );

  assign rx_warn    = st_q.rx_warn;
  assign tx_warn    = st_q.tx_warn;
  assign rx_passive = st_q.rx_pas;
  assign tx_passive = st_q.tx_pas;
  assign bus_off    = st_q.bus_off;
  assign any_warn   = st_q.rx_warn | st_q.tx_warn;
endmodule

// File: rtl/bus_err_mon_chk.sv
module bus_err_mon_chk #(
  parameter int RX_W     = 8,
  parameter int TX_W     = 9,
  parameter int NBUF     = 2,
  parameter int WARN_LIM = 96,
  parameter int PAS_LIM  = 127,
  parameter int BOFF_LIM = 255
) (
  input logic            clk,
  input logic            rst,
  input logic [RX_W-1:0] rx_err_cnt,
  input logic [TX_W-1:0] tx_err_cnt,
  input logic [NBUF-1:0] rx_ovf_evt,
  input logic [NBUF-1:0] ovf_clr,
  input logic            rx_warn,
  input logic            tx_warn,
  input logic            any_warn,
  input logic            rx_passive,
  input logic            tx_passive,
  input logic            bus_off,
  input logic [NBUF-1:0] rx_ovf,
  input logic            err_irq
);
  logic [4:0] fs;
  assign fs = {bus_off, tx_passive, rx_passive, tx_warn, rx_warn};

  p_rx_warn_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rx_warn == ($past(rx_err_cnt) >= RX_W'(WARN_LIM)));
  p_tx_warn_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> tx_warn == ($past(tx_err_cnt) >= TX_W'(WARN_LIM)));
  p_rx_pas_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rx_passive == ($past(rx_err_cnt) > RX_W'(PAS_LIM)));
  p_tx_pas_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> tx_passive == ($past(tx_err_cnt) > TX_W'(PAS_LIM)));
  p_bus_off_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> bus_off == ($past(tx_err_cnt) > TX_W'(BOFF_LIM)));
  p_any_warn_r7: assert property (@(posedge clk) disable iff (rst)
    any_warn == (rx_warn | tx_warn));

  for (genvar i = 0; i < NBUF; i++) begin : g_ovf
    p_ovf_set_r8: assert property (@(posedge clk) disable iff (rst)
      rx_ovf_evt[i] |=> rx_ovf[i]);
    p_ovf_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (rx_ovf[i] && !ovf_clr[i]) |=> rx_ovf[i]);
  end

  p_irq_change_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && fs != $past(fs)) |-> err_irq);
  p_irq_event_r10: assert property (@(posedge clk) disable iff (rst)
    (|rx_ovf_evt) |=> err_irq);
  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(fs) && !$past(|rx_ovf_evt)) |-> !err_irq);
endmodule

bind bus_err_mon bus_err_mon_chk #(
  .RX_W(RX_W), .TX_W(TX_W), .NBUF(NBUF),
  .WARN_LIM(WARN_LIM), .PAS_LIM(PAS_LIM), .BOFF_LIM(BOFF_LIM)
) u_chk (
  .clk(clk), .rst(rst), .rx_err_cnt(rx_err_cnt), .tx_err_cnt(tx_err_cnt),
  .rx_ovf_evt(rx_ovf_evt), .ovf_clr(ovf_clr), .rx_warn(rx_warn),
  .tx_warn(tx_warn), .any_warn(any_warn), .rx_passive(rx_passive),
  .tx_passive(tx_passive), .bus_off(bus_off), .rx_ovf(rx_ovf),
  .err_irq(err_irq)
);

// File: tb/bus_err_mon_test.sv
module bus_err_mon_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] rx_err_cnt = '0;
  logic [8:0] tx_err_cnt = '0;
  logic [1:0] rx_ovf_evt = '0;
  logic [1:0] ovf_clr = '0;
  logic rx_warn, tx_warn, any_warn, rx_passive, tx_passive, bus_off, err_irq;
  logic [1:0] rx_ovf;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz

  bus_err_mon uut (
    .clk(clk), .rst(rst), .rx_err_cnt(rx_err_cnt), .tx_err_cnt(tx_err_cnt),
    .rx_ovf_evt(rx_ovf_evt), .ovf_clr(ovf_clr), .rx_warn(rx_warn),
    .tx_warn(tx_warn), .any_warn(any_warn), .rx_passive(rx_passive),
    .tx_passive(tx_passive), .bus_off(bus_off), .rx_ovf(rx_ovf),
    .err_irq(err_irq)
  );

  // {rx count, tx count, expected {bus_off, tx_pas, rx_pas, tx_warn, rx_warn}}
  localparam int NV = 12;
  localparam logic [21:0] VEC [NV] = '{
    {8'd0,   9'd0,   5'b00000},
    {8'd95,  9'd0,   5'b00000},
    {8'd96,  9'd0,   5'b00001},
    {8'd96,  9'd96,  5'b00011},
    {8'd127, 9'd127, 5'b00011},
    {8'd128, 9'd127, 5'b00111},
    {8'd128, 9'd128, 5'b01111},
    {8'd255, 9'd255, 5'b01111},
    {8'd255, 9'd256, 5'b11111},
    {8'd0,   9'd300, 5'b11010},
    {8'd10,  9'd95,  5'b00000},
    {8'd10,  9'd95,  5'b00000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [4:0] flags();
    return {bus_off, tx_passive, rx_passive, tx_warn, rx_warn};
  endfunction

  initial begin
    logic [4:0] prev;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    step();
    chk("R1 flags after reset", 32'(flags()), 32'd0);
    chk("R1 ovf/irq after reset", 32'({rx_ovf, err_irq}), 32'd0);

    prev = '0;
    for (int i = 0; i < NV; i++) begin
      rx_err_cnt = VEC[i][21:14];
      tx_err_cnt = VEC[i][13:5];
      step();
      chk("R2-R6 flags", 32'(flags()), 32'(VEC[i][4:0]));
      chk("R7 any_warn", 32'(any_warn), 32'(VEC[i][0] | VEC[i][1]));
      chk("R9/R11 irq on change", 32'(err_irq), 32'(VEC[i][4:0] != prev));
      prev = VEC[i][4:0];
    end

    // R8 R10: event sets bit and pulses irq
    rx_ovf_evt = 2'b01;
    step();
    rx_ovf_evt = 2'b00;
    chk("R8 ovf set", 32'(rx_ovf), 32'd1);
    chk("R10 irq on event", 32'(err_irq), 32'd1);
    step();
    chk("R8 ovf sticky", 32'(rx_ovf), 32'd1);
    chk("R11 irq quiet", 32'(err_irq), 32'd0);
    // R10: repeat event on set bit
    rx_ovf_evt = 2'b01;
    step();
    rx_ovf_evt = 2'b00;
    chk("R10 irq on repeat event", 32'(err_irq), 32'd1);
    // R8: clear on empty bit has no effect
    ovf_clr = 2'b10;
    step();
    ovf_clr = 2'b00;
    chk("R8 clear empty bit", 32'(rx_ovf), 32'd1);
    // R8 R11: clear removes bit without irq
    ovf_clr = 2'b01;
    step();
    ovf_clr = 2'b00;
    chk("R8 ovf cleared", 32'(rx_ovf), 32'd0);
    chk("R11 no irq on clear", 32'(err_irq), 32'd0);
    // R8: set and clear together, set wins
    rx_ovf_evt = 2'b10;
    ovf_clr = 2'b10;
    step();
    rx_ovf_evt = 2'b00;
    ovf_clr = 2'b00;
    chk("R8 set beats clear", 32'(rx_ovf), 32'd2);
    chk("R10 irq on buffer 1 event", 32'(err_irq), 32'd1);

    // R1: reset with counters high and overflow set
    rx_err_cnt = 8'd200;
    tx_err_cnt = 9'd300;
    step();
    chk("R9 irq rise", 32'(err_irq), 32'd1);
    rst = 1'b1;
    step();
    chk("R1 mid-run reset flags", 32'(flags()), 32'd0);
    chk("R1 mid-run reset ovf/irq", 32'({rx_ovf, err_irq, any_warn}), 32'd0);
    rst = 1'b0;
    step();
    chk("R2-R6 flags after reset", 32'(flags()), 32'h1f);
    chk("R9 irq after reset release", 32'(err_irq), 32'd1);
    step();
    chk("R11 irq quiet after", 32'(err_irq), 32'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule